// File: doc/BRIEF.md
# Dual-Window On-Chip Memory Decoder

This block places one small on-chip RAM behind two address windows. One window serves instruction fetches and the other serves data accesses. Each window has a base register and a control register. A simple select/enable register bus writes and reads these four registers. The memory port compares every request against the enabled windows. A request that hits is steered to the single shared RAM, and the block answers with an acknowledge and read data one clock later. A request that misses gets no acknowledge.

Both windows reach the same storage, so a word written through one window can be read through the other. The two windows may be programmed to the same base. In that case the request still resolves to exactly one RAM access and one reported window. Turning off or moving one window leaves the other window's mapping intact.

Top module: `ocm_window_decoder`

## Requirements
- R1: After a synchronous reset, all four registers read as zero and both windows are disabled, so no memory request is acknowledged.
- R2: A base register stores only bits 31:26 of the written value, and bits 25:0 read as zero. The register select encoding is 0 = instruction base, 1 = instruction control, 2 = data base, 3 = data control.
- R3: A control register stores only bits 31:30 of the written value, and bits 29:0 read as zero. Bit 31 enables the window. Bit 30 is kept but has no effect on decoding.
- R4: A window hits when its enable bit is set and address bits 31:26 equal its stored base. Address bits 11:2 select the RAM word, and bits 25:12 and 1:0 are ignored. On a hit, `mem_ack` and `mem_rdata` appear on the cycle after the request.
- R5: Both windows address the same physical words. Data written through the data window is returned by a fetch through the instruction window at the same word index, and the reverse also holds.
- R6: If both windows are enabled with equal bases, a request still makes a single access. `hit_win` is one-hot: bit 0 means the instruction window served the request and bit 1 means the data window served it.
- R7: Disabling one window, or moving it away, leaves the other window decoding and acknowledging as before.
- R8: A fetch checks the instruction window first and falls back to the data window. A data access checks only the data window.
- R9: A request that hits no window is not acknowledged, and a write that misses leaves the RAM unchanged.
- R10: If a register write and a memory request occur in the same cycle, the request is decoded with the register values from before the write.
- R11: `cfg_rdata` is updated on the cycle after `cfg_re`. When a read and a write target the same register in one cycle, the read returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_sel | input | 2 | Register select (0 ibase, 1 ictl, 2 dbase, 3 dctl) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered register read data |
| mem_req | input | 1 | Memory request valid |
| mem_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| mem_we | input | 1 | Memory write |
| mem_addr | input | 32 | Byte address |
| mem_wdata | input | 32 | Memory write data |
| mem_ack | output | 1 | Registered acknowledge of a hitting request |
| mem_rdata | output | 32 | Registered read data (contents before any write) |
| hit_win | output | 2 | Registered one-hot record of the window that served the request |

## Verification
A register write and a memory access can land in the same cycle. A window change can therefore race a decode that depends on it. The bench provokes this by clearing the data window's enable while a data read is issued in the same cycle, and then repeating the read on the next cycle. The first read must be acknowledged and the second must not. The random phase also mixes register writes of a few colliding base values with fetches and data accesses. The behavioural model applies register updates only after it has decoded the access of the same cycle, and every output is compared on every clock.

// File: rtl/ocm_pkg.sv
package ocm_pkg;
  localparam int ADDR_W   = 32;
  localparam int BASE_W   = 6;
  localparam int BASE_LSB = ADDR_W - BASE_W;
  localparam int CTL_W    = 2;
  localparam int NUM_WIN  = 2;

  typedef enum logic [1:0] {
    SEL_IBASE = 2'd0,
    SEL_ICTL  = 2'd1,
    SEL_DBASE = 2'd2,
    SEL_DCTL  = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic              en;
    logic              aux;
  } win_cfg_t;
endpackage

// File: rtl/ocm_cfg_regs.sv
module ocm_cfg_regs
  import ocm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output win_cfg_t          win_cfg [NUM_WIN]
);
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NUM_WIN; w++) win_cfg[w] <= '0;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        SEL_IBASE: win_cfg[0].base <= cfg_wdata[DATA_W-1 -: BASE_W];
        SEL_ICTL:  {win_cfg[0].en, win_cfg[0].aux} <= cfg_wdata[DATA_W-1 -: CTL_W];
        SEL_DBASE: win_cfg[1].base <= cfg_wdata[DATA_W-1 -: BASE_W];
        default:   {win_cfg[1].en, win_cfg[1].aux} <= cfg_wdata[DATA_W-1 -: CTL_W];
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    if (cfg_sel[0]) begin
      rd_mux[DATA_W-1 -: CTL_W] = {win_cfg[cfg_sel[1]].en, win_cfg[cfg_sel[1]].aux};
    end else begin
      rd_mux[DATA_W-1 -: BASE_W] = win_cfg[cfg_sel[1]].base;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_re) cfg_rdata <= rd_mux;
  end
endmodule

// File: rtl/ocm_win_match.sv
module ocm_win_match
  import ocm_pkg::*;
(
  input  win_cfg_t          cfg,
  input  logic [BASE_W-1:0] addr_top,
  output logic              hit
);
  assign hit = cfg.en && (addr_top == cfg.base);
endmodule

// File: rtl/ocm_ram.sv
module ocm_ram #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      rdata <= mem[idx];
      if (we) mem[idx] <= wdata;
    end
  end
endmodule

// File: rtl/ocm_window_decoder.sv
module ocm_window_decoder
  import ocm_pkg::*;
#(
  parameter int RAM_BYTES = 4096,
  parameter int DATA_W    = 32,
  localparam int BYTES_W  = DATA_W / 8,
  localparam int LSB_W    = $clog2(BYTES_W),
  localparam int DEPTH    = RAM_BYTES / BYTES_W,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              mem_req,
  input  logic              mem_fetch,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic              mem_ack,
  output logic [DATA_W-1:0] mem_rdata,
  output logic [1:0]        hit_win
);
  win_cfg_t             win_cfg [NUM_WIN];
  logic [NUM_WIN-1:0]   win_hit;
  logic [1:0]           grant;
  logic                 any_en;

  ocm_cfg_regs #(.DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .win_cfg(win_cfg)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    ocm_win_match match_i (
      .cfg(win_cfg[w]),
      .addr_top(mem_addr[ADDR_W-1 -: BASE_W]),
      .hit(win_hit[w])
    );
  end

  assign any_en = win_cfg[0].en || win_cfg[1].en;

  // Fetches prefer the instruction window; data accesses see only the data window.
  always_comb begin
    grant = 2'b00;
    if (mem_req) begin
      if (mem_fetch && win_hit[0]) grant = 2'b01;
      else if (win_hit[1])         grant = 2'b10;
    end
  end

  ocm_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) ram_i (
    .clk(clk), .en(|grant), .we(mem_we),
    .idx(mem_addr[LSB_W +: IDX_W]), .wdata(mem_wdata), .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      hit_win <= 2'b00;
    end else begin
      mem_ack <= |grant;
      hit_win <= grant;
    end
  end
endmodule

// File: rtl/ocm_window_checker.sv
module ocm_window_checker (
  input logic        clk,
  input logic        rst,
  input logic        mem_req,
  input logic        mem_fetch,
  input logic        mem_ack,
  input logic [1:0]  hit_win,
  input logic        cfg_re,
  input logic [1:0]  cfg_sel,
  input logic [31:0] cfg_rdata,
  input logic        any_en
);
  assert_single_window_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_win));

  assert_ack_has_window_R4: assert property (@(posedge clk) disable iff (rst)
    mem_ack |-> (hit_win != 2'b00));

  assert_miss_no_ack_R9: assert property (@(posedge clk) disable iff (rst)
    !mem_req |=> !mem_ack);

  assert_disabled_no_ack_R1: assert property (@(posedge clk) disable iff (rst)
    mem_ack |-> $past(any_en));

  assert_data_only_dwin_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_ack && $past(!mem_fetch)) |-> (hit_win == 2'b10));

  assert_base_reserved_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_re) && $past(cfg_sel[0] == 1'b0)) |-> (cfg_rdata[25:0] == 26'd0));

  assert_ctl_reserved_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_re) && $past(cfg_sel[0] == 1'b1)) |-> (cfg_rdata[29:0] == 30'd0));
endmodule

bind ocm_window_decoder ocm_window_checker chk_i (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_fetch(mem_fetch),
  .mem_ack(mem_ack), .hit_win(hit_win), .cfg_re(cfg_re), .cfg_sel(cfg_sel),
  .cfg_rdata(cfg_rdata), .any_en(any_en)
);

// File: tb/ocm_window_decoder_tb.sv
module ocm_window_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we, cfg_re;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        mem_req, mem_fetch, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ack;
  logic [1:0]  hit_win;

  always #4 clk = ~clk;

  ocm_window_decoder dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
    .mem_fetch(mem_fetch), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .hit_win(hit_win)
  );

  // Behavioural reference state
  logic [31:0] m_ram [1024];
  logic [31:0] m_reg [4];
  int          n_vec = 0;
  int          n_bad = 0;

  // Expectations for the next compare
  bit          e_valid = 0;
  bit          e_ack;
  logic [1:0]  e_hit;
  bit          e_rd_chk;
  logic [31:0] e_rd;
  bit          e_cfg_chk;
  logic [31:0] e_cfg;
  string       e_tag = "";

  task automatic miscompare(string what, logic [31:0] act, logic [31:0] exp);
    n_bad++;
    $display("FAIL %s %s: actual %h expected %h", e_tag, what, act, exp);
  endtask

  always @(negedge clk) begin
    if (e_valid) begin
      n_vec++;
      if (mem_ack !== e_ack) miscompare("mem_ack", 32'(mem_ack), 32'(e_ack));
      if (hit_win !== e_hit) miscompare("hit_win", 32'(hit_win), 32'(e_hit));
      if (e_rd_chk && mem_rdata !== e_rd) miscompare("mem_rdata", mem_rdata, e_rd);
      if (e_cfg_chk && cfg_rdata !== e_cfg) miscompare("cfg_rdata", cfg_rdata, e_cfg);
    end
  end

  function automatic logic [31:0] keep_mask(logic [1:0] sel);
    return sel[0] ? 32'hC000_0000 : 32'hFC00_0000;
  endfunction

  task automatic drv(string tag, bit r, bit req, bit f, bit we,
                     logic [31:0] a, logic [31:0] wd,
                     bit cwe, bit cre, logic [1:0] cs, logic [31:0] cwd);
    bit ih, dh;
    @(negedge clk); #1;
    rst = r; mem_req = req; mem_fetch = f; mem_we = we; mem_addr = a;
    mem_wdata = wd; cfg_we = cwe; cfg_re = cre; cfg_sel = cs; cfg_wdata = cwd;
    e_tag = tag; e_valid = 1; e_rd_chk = 0;
    if (r) begin
      e_ack = 0; e_hit = 2'b00; e_cfg_chk = 1; e_cfg = 32'h0;
      for (int i = 0; i < 4; i++) m_reg[i] = 32'h0;
      return;
    end
    // Decode against the registers as they stand before this edge (R10)
    ih = m_reg[1][31] && (a[31:26] == m_reg[0][31:26]);
    dh = m_reg[3][31] && (a[31:26] == m_reg[2][31:26]);
    e_hit = 2'b00;
    if (req) begin
      if (f && ih) e_hit = 2'b01;
      else if (dh) e_hit = 2'b10;
    end
    e_ack = (e_hit != 2'b00);
    if (e_ack) begin
      e_rd = m_ram[a[11:2]];
      e_rd_chk = !we;
      if (we) m_ram[a[11:2]] = wd;
    end
    if (cre) begin
      e_cfg_chk = 1; e_cfg = m_reg[cs];
    end
    if (cwe) m_reg[cs] = cwd & keep_mask(cs);
  endtask

  task automatic idle(string tag);
    drv(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic rd(string tag, bit f, logic [31:0] a);
    drv(tag, 0, 1, f, 0, a, 32'h0, 0, 0, 0, 0);
  endtask
  task automatic wr(string tag, bit f, logic [31:0] a, logic [31:0] d);
    drv(tag, 0, 1, f, 1, a, d, 0, 0, 0, 0);
  endtask
  task automatic rw(string tag, logic [1:0] s, logic [31:0] v);
    drv(tag, 0, 0, 0, 0, 0, 0, 1, 0, s, v);
  endtask
  task automatic rr(string tag, logic [1:0] s);
    drv(tag, 0, 0, 0, 0, 0, 0, 0, 1, s, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst = 1; mem_req = 0; mem_fetch = 0; mem_we = 0; mem_addr = 0; mem_wdata = 0;
    cfg_we = 0; cfg_re = 0; cfg_sel = 0; cfg_wdata = 0;
    for (int i = 0; i < 3; i++) drv("R1 reset", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R1: registers zero, accesses not acknowledged
    for (int s = 0; s < 4; s++) rr("R1 reg", 2'(s));
    rd("R1 fetch", 1, 32'h0000_0000);
    rd("R1 data", 0, 32'h0000_0010);
    // R2 / R3: masks on write and read
    rw("R2", 0, 32'hFFFF_FFFF); rr("R2", 0);
    rw("R3", 1, 32'h7FFF_FFFF); rr("R3", 1);
    rw("R3", 3, 32'h4000_0000); rr("R3", 3);
    rd("R3 aux bit does not enable", 0, 32'h0000_0000);
    rw("R2", 2, 32'h03FF_FFFF); rr("R2", 2);
    // R4: instruction window at 0x1C000000, fill RAM through it
    rw("R4", 0, 32'h1C00_0000);
    rw("R4", 1, 32'h8000_0000);
    for (int i = 0; i < 1024; i++)
      wr("R4 fill", 1, 32'h1C00_0000 + 32'(i * 4), 32'hA5000000 ^ 32'(i * 32'h9E37));
    for (int i = 0; i < 16; i++)
      rd("R4 alias bits ignored", 1, 32'h1C12_3003 | 32'(i * 68));
    rd("R4 miss other base", 1, 32'h2000_0000);
    // R8: data access must not use instruction window
    rd("R8 data no ifetch window", 0, 32'h1C00_0040);
    // R5: data window elsewhere, shares storage
    rw("R5", 2, 32'h2000_0000); rw("R5", 3, 32'h8000_0000);
    wr("R5 write via data", 0, 32'h2000_0100, 32'hDEAD_BEEF);
    rd("R5 read via fetch", 1, 32'h1C00_0100);
    wr("R5 write via fetch", 1, 32'h1C00_0204, 32'h1234_5678);
    rd("R5 read via data", 0, 32'h2000_0204);
    // R6: equal bases, single access
    rw("R6", 2, 32'h1C00_0000);
    rd("R6 fetch", 1, 32'h1C00_0100);
    rd("R6 data", 0, 32'h1C00_0204);
    wr("R6 write", 0, 32'h1C00_0300, 32'hCAFE_F00D);
    rd("R6 back", 1, 32'h1C00_0300);
    // R7 / R8: disable instruction window, data window keeps mapping
    rw("R7", 1, 32'h0);
    rd("R7 data still", 0, 32'h1C00_0300);
    rd("R8 fetch falls back", 1, 32'h1C00_0100);
    rw("R7 move data", 2, 32'h4400_0000);
    rw("R7", 1, 32'h8000_0000);
    rd("R7 ifetch kept", 1, 32'h1C00_0300);
    rd("R7 data moved", 0, 32'h4400_0300);
    rd("R7 data old base", 0, 32'h1C00_0300);
    // R9: miss write leaves RAM unchanged
    wr("R9 miss", 0, 32'h8000_0300, 32'h0BAD_0BAD);
    wr("R9 miss", 1, 32'h8000_0300, 32'h0BAD_0BAD);
    rd("R9 unchanged", 1, 32'h1C00_0300);
    // R10: config write same cycle as access
    drv("R10 same cycle", 0, 1, 0, 0, 32'h4400_0300, 0, 1, 0, 3, 32'h0);
    rd("R10 after", 0, 32'h4400_0300);
    drv("R10 enable same cycle", 0, 1, 0, 0, 32'h4400_0300, 0, 1, 0, 3, 32'h8000_0000);
    rd("R10 enabled", 0, 32'h4400_0300);
    // R11: read and write same register
    drv("R11 read old", 0, 0, 0, 0, 0, 0, 1, 1, 2, 32'h2400_0000);
    rr("R11 read new", 2);
    idle("R11 hold");
    // Random mix
    for (int n = 0; n < 6000; n++) begin
      int k = $urandom_range(0, 9);
      logic [31:0] bases [4] = '{32'h1C00_0000, 32'h2400_0000, 32'h4400_0000, 32'h0000_0000};
      logic [31:0] a = bases[$urandom_range(0, 3)] | ($urandom & 32'h03FF_FFFF);
      if (k == 0)
        drv("R10 random", 0, 1, 1'($urandom), 1'($urandom), a, $urandom,
            1, 1'($urandom), 2'($urandom), $urandom | 32'h8000_0000);
      else if (k == 1)
        drv("R11 random", 0, 0, 0, 0, 0, 0, 1'($urandom), 1, 2'($urandom),
            bases[$urandom_range(0, 3)]);
      else
        drv("R4 random", 0, 1'($urandom_range(0, 7) != 0), 1'($urandom),
            1'($urandom_range(0, 3) == 0), a, $urandom, 0, 0, 0, 0);
    end
    idle("end");
    @(negedge clk); #1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule